// File: doc/BRIEF.md
# Four-Line Fully Associative Tag-Match Cache

The block is a small cache in which any line can hold any tag. Each of its four lines stores a valid flag, a tag and a data word. Software or a test controller fills the lines directly through a write port, naming the target line with an index. The block never picks a victim and never fetches from memory. Reads work by latching an address, treating all of it as a tag, and comparing that tag against every line at the same time. The block reports a hit flag and the data of the matching line.

Three control inputs choose the operation. With `wr_sel_i=1`, `addr_ld_i=0` and `line_ctl_i=0` the cache is in write mode, and it loads valid, tag and data into the line chosen by `line_sel_i`. With `wr_sel_i=0`, `addr_ld_i=1` and `line_ctl_i=1` it is in lookup mode. Any other combination of the three inputs is idle. The address register captures `addr_i` on every rising edge where `addr_ld_i=1`, whatever the mode. The lookup result is combinational: it is formed from the latched address, the stored lines and the current mode inputs. Tag width, data width and line count are parameters.

Top module: `assoc_tag_cache`

## Requirements
- R1: While `rst_ni` is low, every line is invalid and the address register holds 0, so a lookup straight after reset gives `hit_o=0` and `data_o=0`.
- R2: In write mode (`wr_sel_i=1`, `addr_ld_i=0`, `line_ctl_i=0`), the rising edge loads `valid_i`, `tag_i` and `data_i` into line `line_sel_i` (0 to 3). Every other line is left unchanged.
- R3: In lookup mode (`wr_sel_i=0`, `addr_ld_i=1`, `line_ctl_i=1`), the cache hits when a valid line holds a tag equal to the latched address. It then gives `hit_o=1` and `data_o` equal to that line's data.
- R4: A line whose tag matches but whose valid flag is 0 does not hit.
- R5: On a lookup miss, `hit_o=0` and `data_o=0`.
- R6: The address register captures `addr_i` on a rising edge only when `addr_ld_i=1`. The lookup compares against the registered value, not against `addr_i` directly.
- R7: When more than one valid line matches, the line with the lowest index supplies `data_o`.
- R8: Any control combination other than write mode or lookup mode writes no line, and gives `hit_o=0` and `data_o=0`.
- R9: A lookup, whether it hits or misses, changes no stored line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_sel_i | input | 1 | Mode select: 1 chooses write, 0 chooses lookup |
| addr_ld_i | input | 1 | Address register load; must be 1 for lookup |
| line_ctl_i | input | 1 | Line port control: 0 for write, 1 for lookup |
| addr_i | input | TAG_W (2) | Lookup address, used in full as the tag |
| line_sel_i | input | IDX_W (2) | Index of the line to write |
| valid_i | input | 1 | Valid flag to write |
| tag_i | input | TAG_W (2) | Tag to write |
| data_i | input | DATA_W (2) | Data word to write |
| hit_o | output | 1 | 1 on a lookup hit |
| data_o | output | DATA_W (2) | Data of the hit line, 0 otherwise |

## Verification
The assertions assume that the control inputs and `line_sel_i` are settled and known at each rising edge. They also assume that `line_sel_i` names a line that exists. The stimulus changes all inputs only on the falling edge, and it draws every line index from 0 to 3. The stimulus deliberately loads several lines with the same tag, and it drives the idle control combinations with live write data. This ensures that the priority and no-write properties are actually exercised and are not satisfied trivially.

// File: rtl/assoc_cache_pkg.sv
package assoc_cache_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_WRITE  = 2'd1,
    MODE_LOOKUP = 2'd2
  } cache_mode_e;
endpackage

// File: rtl/cache_mode_decode.sv
module cache_mode_decode
  import assoc_cache_pkg::*;
(
  input  logic        wr_sel_i,
  input  logic        addr_ld_i,
  input  logic        line_ctl_i,
  output cache_mode_e mode_o
);
  always_comb begin
    unique case ({wr_sel_i, addr_ld_i, line_ctl_i})
      3'b100:  mode_o = MODE_WRITE;
      3'b011:  mode_o = MODE_LOOKUP;
      default: mode_o = MODE_IDLE;
    endcase
  end
endmodule

// File: rtl/cache_line_store.sv
module cache_line_store #(
  parameter int LINES  = 4,
  parameter int TAG_W  = 2,
  parameter int DATA_W = 2,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [IDX_W-1:0]               sel_i,
  input  logic                           valid_i,
  input  logic [TAG_W-1:0]               tag_i,
  input  logic [DATA_W-1:0]              data_i,
  output logic [LINES-1:0]               valid_o,
  output logic [LINES-1:0][TAG_W-1:0]    tag_o,
  output logic [LINES-1:0][DATA_W-1:0]   data_o
);
  logic [LINES-1:0]             valid_q;
  logic [LINES-1:0][TAG_W-1:0]  tag_q;
  logic [LINES-1:0][DATA_W-1:0] data_q;
  logic [LINES-1:0]             line_we;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign line_we[g] = we_i && (sel_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        tag_q[g]   <= '0;
        data_q[g]  <= '0;
      end else if (line_we[g]) begin
        valid_q[g] <= valid_i;
        tag_q[g]   <= tag_i;
        data_q[g]  <= data_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;
  assign data_o  = data_q;

  // R8, R9: without a write enable nothing stored may move
  assert_no_write_when_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(valid_q) && $stable(tag_q) && $stable(data_q)));

  // R2: selected line receives the supplied fields
  assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (valid_q[$past(sel_i)] == $past(valid_i) &&
              tag_q[$past(sel_i)]   == $past(tag_i) &&
              data_q[$past(sel_i)]  == $past(data_i)));

  // R2: at most one line written per cycle
  assert_single_line_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(line_we));
endmodule

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
  parameter int LINES  = 4,
  parameter int TAG_W  = 2,
  parameter int DATA_W = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         en_i,
  input  logic [TAG_W-1:0]             key_i,
  input  logic [LINES-1:0]             valid_i,
  input  logic [LINES-1:0][TAG_W-1:0]  tag_i,
  input  logic [LINES-1:0][DATA_W-1:0] data_i,
  output logic                         hit_o,
  output logic [DATA_W-1:0]            data_o
);
  logic [LINES-1:0] match;

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (tag_i[g] == key_i);
  end

  // lowest-index match wins: scan downward so the last assignment is the lowest
  always_comb begin
    hit_o  = 1'b0;
    data_o = '0;
    if (en_i) begin
      for (int i = LINES - 1; i >= 0; i--) begin
        if (match[i]) begin
          hit_o  = 1'b1;
          data_o = data_i[i];
        end
      end
    end
  end

  // R4: a hit needs at least one valid line
  assert_hit_needs_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (valid_i != '0));

  // R5: miss yields zero data
  assert_miss_zero_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (data_o == '0));

  // R8: outside lookup, no hit
  assert_idle_no_hit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !hit_o);

  // R7: lowest line wins when line 0 matches
  assert_line0_priority_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && match[0]) |-> (hit_o && data_o == data_i[0]));
endmodule

// File: rtl/assoc_tag_cache.sv
module assoc_tag_cache
  import assoc_cache_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int TAG_W  = 2,
  parameter int DATA_W = 2,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_sel_i,
  input  logic              addr_ld_i,
  input  logic              line_ctl_i,
  input  logic [TAG_W-1:0]  addr_i,
  input  logic [IDX_W-1:0]  line_sel_i,
  input  logic              valid_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] data_o
);
  cache_mode_e                  mode;
  logic [TAG_W-1:0]             addr_q;
  logic [LINES-1:0]             st_valid;
  logic [LINES-1:0][TAG_W-1:0]  st_tag;
  logic [LINES-1:0][DATA_W-1:0] st_data;

  cache_mode_decode u_mode (
    .wr_sel_i   (wr_sel_i),
    .addr_ld_i  (addr_ld_i),
    .line_ctl_i (line_ctl_i),
    .mode_o     (mode)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        addr_q <= '0;
    else if (addr_ld_i) addr_q <= addr_i;
  end

  cache_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mode == MODE_WRITE),
    .sel_i   (line_sel_i),
    .valid_i (valid_i),
    .tag_i   (tag_i),
    .data_i  (data_i),
    .valid_o (st_valid),
    .tag_o   (st_tag),
    .data_o  (st_data)
  );

  cache_tag_match #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (mode == MODE_LOOKUP),
    .key_i   (addr_q),
    .valid_i (st_valid),
    .tag_i   (st_tag),
    .data_i  (st_data),
    .hit_o   (hit_o),
    .data_o  (data_o)
  );

  // R6: register holds when not loading
  assert_addr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_ld_i |=> $stable(addr_q));

  // R6: register follows the pins when loading
  assert_addr_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_ld_i |=> (addr_q == $past(addr_i)));

  // R9: a lookup never alters storage
  assert_lookup_no_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_LOOKUP) |=> ($stable(st_valid) && $stable(st_tag) && $stable(st_data)));
endmodule

// File: tb/assoc_tag_cache_tb.sv
module assoc_tag_cache_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s, a, d, v;
  logic [1:0] addr, sel, tag, dat;
  logic       hit;
  logic [1:0] dout;

  int checks = 0;
  int fails  = 0;

  // behavioural model state
  int m_valid [4];
  int m_tag   [4];
  int m_data  [4];
  int m_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  assoc_tag_cache u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_sel_i(s), .addr_ld_i(a), .line_ctl_i(d),
    .addr_i(addr), .line_sel_i(sel), .valid_i(v), .tag_i(tag), .data_i(dat),
    .hit_o(hit), .data_o(dout)
  );

  task automatic check_out(input string req);
    int exp_hit = 0;
    int exp_dat = 0;
    if (s == 1'b0 && a == 1'b1 && d == 1'b1) begin
      for (int i = 3; i >= 0; i--)
        if (m_valid[i] == 1 && m_tag[i] == m_addr) begin
          exp_hit = 1;
          exp_dat = m_data[i];
        end
    end
    checks++;
    if (int'(hit) != exp_hit || int'(dout) != exp_dat) begin
      fails++;
      $display("FAIL %s: hit=%0d data=%0d expected hit=%0d data=%0d",
               req, hit, dout, exp_hit, exp_dat);
    end
  endtask

  task automatic step(input logic ts, input logic ta, input logic td,
                      input int taddr, input int tsel, input int tv,
                      input int ttag, input int tdat, input string req);
    s = ts; a = ta; d = td;
    addr = 2'(taddr); sel = 2'(tsel); v = 1'(tv); tag = 2'(ttag); dat = 2'(tdat);
    #1;
    check_out(req);
    @(posedge clk);
    if (ts == 1'b1 && ta == 1'b0 && td == 1'b0) begin
      m_valid[tsel] = tv; m_tag[tsel] = ttag; m_data[tsel] = tdat;
    end
    if (ta) m_addr = taddr;
    @(negedge clk);
  endtask

  task automatic wr(input int tsel, input int tv, input int ttag, input int tdat);
    step(1'b1, 1'b0, 1'b0, 0, tsel, tv, ttag, tdat, "R2");
  endtask

  // lookup takes two steps: latch on first edge, result visible after it
  task automatic look(input int taddr, input string req);
    step(1'b0, 1'b1, 1'b1, taddr, 0, 0, 0, 0, req);
    step(1'b0, 1'b1, 1'b1, taddr, 0, 0, 0, 0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog: timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_valid[i] = 0; m_tag[i] = 0; m_data[i] = 0; end
    m_addr = 0;
    s = 0; a = 1; d = 1; addr = 0; sel = 0; v = 0; tag = 0; dat = 0;
    #(CLK_PERIOD * 2 + 2);
    // R1: reset state seen through a lookup before release
    check_out("R1");
    @(negedge clk);
    rst_n = 1'b1;
    for (int t = 0; t < 4; t++) look(t, "R1");

    // R2 example contents
    wr(0, 1, 2, 3);
    wr(1, 1, 1, 2);
    wr(2, 0, 0, 1);
    look(2, "R3");
    look(1, "R3");
    look(3, "R5");
    look(0, "R4");

    // R7: duplicate tag in line 3, line 0 still wins
    wr(3, 1, 2, 1);
    look(2, "R7");
    wr(0, 0, 2, 3);
    look(2, "R7");
    wr(1, 1, 2, 0);
    wr(0, 1, 2, 3);
    look(2, "R7");

    // R8: every idle combination with live write data
    for (int c = 0; c < 8; c++) begin
      if (c != 3'b100 && c != 3'b011)
        step(c[2], c[1], c[0], c % 4, c % 4, 1, 3, c % 4, "R8");
    end
    for (int t = 0; t < 4; t++) look(t, "R8");

    // R6: pins move while not loading; first lookup cycle uses held value
    look(2, "R6");
    step(1'b1, 1'b0, 1'b0, 3, 2, 1, 0, 2, "R6");
    step(1'b1, 1'b0, 1'b0, 0, 2, 1, 0, 2, "R6");
    step(1'b0, 1'b1, 1'b1, 0, 0, 0, 0, 0, "R6");
    step(1'b0, 1'b1, 1'b1, 0, 0, 0, 0, 0, "R6");

    // R9: repeated misses and hits leave contents intact
    for (int t = 0; t < 4; t++) look(t, "R9");
    look(3, "R9");
    look(2, "R9");

    // sweep of all lines and tags
    for (int ln = 0; ln < 4; ln++) wr(ln, ln % 2, 3 - ln, ln);
    for (int t = 0; t < 4; t++) look(t, "R3");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule